// File: doc/BRIEF.md
# Serial Receiver Register Interface

This block is the processor-side register file of a small asynchronous serial controller. The bit shifter and baud logic live elsewhere. When a character is finished, that logic pulses a strobe with the received byte and its parity and framing error flags. The block captures the byte in a holding register and keeps four sticky receive flags. It drives a receive-ready pin that mirrors the ready flag. It also stores the configuration the shifter uses: two mode registers, two sync characters and a command register.

The processor sees four addresses. Address 0 reads the received byte. Address 1 reads the status flags, and a write there loads a sync character. Address 2 reaches the two mode registers. Address 3 holds the command. The mode registers share one address and are selected by a one-bit index that alternates on each access. The sync characters use a second alternating index in the same way. A non-peek read of the command register returns both indices to zero.

A peek input lets a debugger read any address without consuming the received byte and without moving either index.

Top module: `sercon_regif`

## Requirements
- R1: A `char_done` pulse loads `char_data` into the holding register and sets the ready flag (status bit 0). `rx_ready_o` is high from the following cycle.
- R2: `char_perr` with `char_done` sets status bit 1, and `char_ferr` with `char_done` sets status bit 3. Both bits stay set until the receiver is disabled (R9). Reading the holding register does not clear them.
- R3: A non-peek read of address 0 returns the held byte in the same cycle. It clears the ready flag and `rx_ready_o` from the next cycle. If `char_done` arrives in the same cycle, the new byte is loaded and ready stays set.
- R4: A `char_done` that arrives while ready is set overwrites the holding register and sets the overrun flag (status bit 2). The exception is a cycle in which ready is being cleared by a holding read or a receiver disable.
- R5: The mode index is 0 after reset. A read of address 2 returns mode register [index], and a write of address 2 loads mode register [index]. After either access the index flips. A peek read does not flip it.
- R6: A write of address 1 loads sync character [sync index] and then flips the sync index, which is 0 after reset. `sync0_o` and `sync1_o` show the two characters.
- R7: A non-peek read of address 3 returns the command register and sets both the mode index and the sync index to 0.
- R8: With `cpu_peek` high, reads return the same data as normal reads but change no flag, no index and no pin.
- R9: A write of address 3 with bit 2 (receiver enable) clear sets status bits 3:0 to zero and drops `rx_ready_o` from the next cycle. A `char_done` in the same cycle is still recorded on top of the cleared flags.
- R10: Status reads place ready, parity, overrun and framing in bits 0 to 3, with bits 7:4 zero. `cpu_rdata` is zero whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_peek | input | 1 | Read without side effects |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| char_done | input | 1 | Character-complete strobe |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity error on this character |
| char_ferr | input | 1 | Framing error on this character |
| rx_ready_o | output | 1 | Receive-ready pin |
| mode0_o | output | 8 | Mode register 0 |
| mode1_o | output | 8 | Mode register 1 |
| sync0_o | output | 8 | Sync character 0 |
| sync1_o | output | 8 | Sync character 1 |
| cmd_o | output | 8 | Command register |

## Verification
The hardest cases are collisions in a single cycle: a character arriving while the byte is being read, and a character arriving while the receiver is being disabled. In both, the clear and the set act on the same flags. The bench drives the strobe and the bus access on the same falling edge so that both land on one rising edge. It then reads status to confirm that ready survives and that overrun is not raised. The index sequencing is traced with a vector table. The table mixes peek and normal reads of the mode and command addresses, so any stray index flip shows up as the wrong mode register being returned.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

    typedef enum logic [1:0] {
        ADDR_HOLD = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_MODE = 2'd2,
        ADDR_CMD  = 2'd3
    } sc_addr_e;

    localparam int ST_RDY   = 0;
    localparam int ST_PAR   = 1;
    localparam int ST_OVR   = 2;
    localparam int ST_FRM   = 3;
    localparam int ST_W     = 4;
    localparam int CMD_RXEN = 2;

    typedef struct packed {
        logic frm;
        logic ovr;
        logic par;
        logic rdy;
    } rx_flags_t;

endpackage

// File: rtl/sercon_rxstat.sv
module sercon_rxstat
    import sercon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              rd_take,
    input  logic              rx_off,
    output logic [DATA_W-1:0] hold_o,
    output rx_flags_t         flags_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        rx_flags_t         flg;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_off) begin
            st_d.flg = '0;
        end
        if (rd_take) begin
            st_d.flg.rdy = 1'b0;
        end
        if (char_done) begin
            st_d.hold = char_data;
            if (st_q.flg.rdy && !rd_take && !rx_off) begin
                st_d.flg.ovr = 1'b1;
            end
            st_d.flg.rdy = 1'b1;
            if (char_perr) st_d.flg.par = 1'b1;
            if (char_ferr) st_d.flg.frm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o  = st_q.hold;
    assign flags_o = st_q.flg;

endmodule

// File: rtl/sercon_regpair.sv
module sercon_regpair #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              clr,
    output logic              idx_o,
    output logic [DATA_W-1:0] reg0_o,
    output logic [DATA_W-1:0] reg1_o
);

    localparam int NREG = 2;

    typedef struct packed {
        logic                        idx;
        logic [NREG-1:0][DATA_W-1:0] r;
    } pair_t;

    pair_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_en) begin
            p_d.r[p_q.idx] = wdata;
        end
        if (clr) begin
            p_d.idx = 1'b0;
        end else if (step) begin
            p_d.idx = ~p_q.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign idx_o  = p_q.idx;
    assign reg0_o = p_q.r[0];
    assign reg1_o = p_q.r[1];

endmodule

// File: rtl/sercon_regif.sv
module sercon_regif
    import sercon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_peek,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    output logic              rx_ready_o,
    output logic [DATA_W-1:0] mode0_o,
    output logic [DATA_W-1:0] mode1_o,
    output logic [DATA_W-1:0] sync0_o,
    output logic [DATA_W-1:0] sync1_o,
    output logic [DATA_W-1:0] cmd_o
);

    sc_addr_e          addr;
    logic              rd_acc, wr_acc, live_rd;
    logic              rd_take, rx_off, cmd_wr;
    logic              mode_wr, mode_step, sync_wr, idx_clr;
    logic              mode_idx, sync_idx;
    logic [DATA_W-1:0] hold;
    rx_flags_t         flags;
    logic [ST_W-1:0]   stat_lo;
    logic [DATA_W-1:0] stat_vec;
    logic [DATA_W-1:0] cmd_d, cmd_q;

    assign addr    = sc_addr_e'(cpu_addr);
    assign rd_acc  = cpu_sel && !cpu_wr;
    assign wr_acc  = cpu_sel && cpu_wr;
    assign live_rd = rd_acc && !cpu_peek;

    assign rd_take   = live_rd && (addr == ADDR_HOLD);
    assign cmd_wr    = wr_acc && (addr == ADDR_CMD);
    assign rx_off    = cmd_wr && !cpu_wdata[CMD_RXEN];
    assign mode_wr   = wr_acc && (addr == ADDR_MODE);
    assign mode_step = mode_wr || (live_rd && (addr == ADDR_MODE));
    assign sync_wr   = wr_acc && (addr == ADDR_STAT);
    assign idx_clr   = live_rd && (addr == ADDR_CMD);

    sercon_rxstat #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .char_data (char_data),
        .char_perr (char_perr),
        .char_ferr (char_ferr),
        .rd_take   (rd_take),
        .rx_off    (rx_off),
        .hold_o    (hold),
        .flags_o   (flags)
    );

    sercon_regpair #(.DATA_W(DATA_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mode_wr),
        .wdata  (cpu_wdata),
        .step   (mode_step),
        .clr    (idx_clr),
        .idx_o  (mode_idx),
        .reg0_o (mode0_o),
        .reg1_o (mode1_o)
    );

    sercon_regpair #(.DATA_W(DATA_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sync_wr),
        .wdata  (cpu_wdata),
        .step   (sync_wr),
        .clr    (idx_clr),
        .idx_o  (sync_idx),
        .reg0_o (sync0_o),
        .reg1_o (sync1_o)
    );

    always_comb begin
        cmd_d = cmd_q;
        if (cmd_wr) cmd_d = cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        stat_lo         = '0;
        stat_lo[ST_RDY] = flags.rdy;
        stat_lo[ST_PAR] = flags.par;
        stat_lo[ST_OVR] = flags.ovr;
        stat_lo[ST_FRM] = flags.frm;
        stat_vec        = '0;
        stat_vec[ST_W-1:0] = stat_lo;
    end

    always_comb begin
        cpu_rdata = '0;
        if (rd_acc) begin
            unique case (addr)
                ADDR_HOLD: cpu_rdata = hold;
                ADDR_STAT: cpu_rdata = stat_vec;
                ADDR_MODE: cpu_rdata = mode_idx ? mode1_o : mode0_o;
                ADDR_CMD:  cpu_rdata = cmd_q;
                default:   cpu_rdata = '0;
            endcase
        end
    end

    assign rx_ready_o = flags.rdy;
    assign cmd_o      = cmd_q;

endmodule

// File: rtl/sercon_regif_chk.sv
module sercon_regif_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [1:0]        cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_peek,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              char_done,
    input logic              rx_ready_o,
    input logic [3:0]        stat_lo,
    input logic              mode_idx,
    input logic              sync_idx
);

    logic hold_rd, cmd_rd, mode_acc, off_wr;
    assign hold_rd  = cpu_sel && !cpu_wr && !cpu_peek && (cpu_addr == 2'd0);
    assign cmd_rd   = cpu_sel && !cpu_wr && !cpu_peek && (cpu_addr == 2'd3);
    assign mode_acc = cpu_sel && (cpu_addr == 2'd2) && (cpu_wr || !cpu_peek);
    assign off_wr   = cpu_sel && cpu_wr && (cpu_addr == 2'd3) && !cpu_wdata[2];

    AST_CHAR_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_ready_o);  // R1

    AST_HOLD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd && !char_done) |=> !rx_ready_o);  // R3

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_ready_o && !hold_rd && !off_wr) |=> stat_lo[2]);  // R4

    AST_MODE_IDX_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_acc |=> (mode_idx != $past(mode_idx)));  // R5

    AST_CMD_READ_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> (!mode_idx && !sync_idx));  // R7

    AST_PEEK_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && cpu_peek && rx_ready_o) |=> rx_ready_o);  // R8

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (off_wr && !char_done) |=> (stat_lo == 4'd0 && !rx_ready_o));  // R9

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && !cpu_wr) |-> (cpu_rdata == '0));  // R10

    AST_PIN_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && cpu_addr == 2'd1) |-> (cpu_rdata[0] == rx_ready_o));  // R10

endmodule

bind sercon_regif sercon_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_sel    (cpu_sel),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_peek   (cpu_peek),
    .cpu_rdata  (cpu_rdata),
    .char_done  (char_done),
    .rx_ready_o (rx_ready_o),
    .stat_lo    (stat_lo),
    .mode_idx   (mode_idx),
    .sync_idx   (sync_idx)
);

// File: tb/sercon_regif_tb_top.sv
module sercon_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_peek = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       char_done = 1'b0, char_perr = 1'b0, char_ferr = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       rx_ready_o;
    logic [7:0] mode0_o, mode1_o, sync0_o, sync1_o, cmd_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sercon_regif dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_peek(cpu_peek),
        .cpu_rdata(cpu_rdata), .char_done(char_done), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .rx_ready_o(rx_ready_o),
        .mode0_o(mode0_o), .mode1_o(mode1_o), .sync0_o(sync0_o),
        .sync1_o(sync1_o), .cmd_o(cmd_o)
    );

    // vector: wr, addr, wdata, peek, check, expected rdata
    localparam int NV = 16;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 2'd2, 8'h11, 1'b0, 1'b0, 8'h00},  // R5 mode0 <= 11
        {1'b1, 2'd2, 8'h22, 1'b0, 1'b0, 8'h00},  // R5 mode1 <= 22
        {1'b0, 2'd2, 8'h00, 1'b1, 1'b1, 8'h11},  // R8 peek, idx stays 0
        {1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 8'h11},  // R5 read idx0
        {1'b0, 2'd2, 8'h00, 1'b1, 1'b1, 8'h22},  // R8 peek idx1
        {1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 8'h22},  // R5 read idx1
        {1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 8'h11},  // R5 back to idx0, now 1
        {1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 8'h00},  // R8 peek cmd
        {1'b0, 2'd2, 8'h00, 1'b1, 1'b1, 8'h22},  // R8 idx still 1
        {1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 8'h00},  // R7 cmd read resets
        {1'b0, 2'd2, 8'h00, 1'b1, 1'b1, 8'h11},  // R7 idx is 0
        {1'b1, 2'd3, 8'h04, 1'b0, 1'b0, 8'h00},  // enable receiver
        {1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 8'h04},  // R7 cmd read
        {1'b1, 2'd1, 8'hA5, 1'b0, 1'b0, 8'h00},  // R6 sync0
        {1'b1, 2'd1, 8'h5A, 1'b0, 1'b0, 8'h00},  // R6 sync1
        {1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 8'h00}   // R10 status clear
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_peek = 1'b0; char_done = 1'b0;
        char_perr = 1'b0; char_ferr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_peek = 1'b0;
        idle();
    endtask

    task automatic rd(input logic [1:0] a, input logic pk, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a; cpu_peek = pk;
        #1 d = cpu_rdata;
        idle();
    endtask

    task automatic chr(input logic [7:0] d, input logic pe, input logic fe);
        @(negedge clk);
        char_done = 1'b1; char_data = d; char_perr = pe; char_ferr = fe;
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        #1 check("R1 reset pin", {7'd0, rx_ready_o}, 8'h00);
        check("R10 idle rdata", cpu_rdata, 8'h00);
        rd(2'd1, 1'b0, v); check("R10 reset status", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cpu_sel = 1'b1; cpu_wr = VEC[i][20]; cpu_addr = VEC[i][19:18];
            cpu_wdata = VEC[i][17:10]; cpu_peek = VEC[i][9];
            #1;
            if (VEC[i][8]) check($sformatf("R5/R7/R8 vec %0d", i), cpu_rdata, VEC[i][7:0]);
        end
        idle();
        check("R5 mode0", mode0_o, 8'h11);
        check("R5 mode1", mode1_o, 8'h22);
        check("R6 sync0", sync0_o, 8'hA5);
        check("R6 sync1", sync1_o, 8'h5A);

        // sync index reset by command read
        wr(2'd1, 8'h33);
        check("R6 sync0 rewrite", sync0_o, 8'h33);
        rd(2'd3, 1'b0, v);
        wr(2'd1, 8'h66);
        check("R7 sync idx reset", sync0_o, 8'h66);
        check("R7 sync1 kept", sync1_o, 8'h5A);

        // receive path
        chr(8'h3C, 1'b0, 1'b0);
        check("R1 pin set", {7'd0, rx_ready_o}, 8'h01);
        rd(2'd0, 1'b1, v); check("R8 peek hold", v, 8'h3C);
        check("R8 pin after peek", {7'd0, rx_ready_o}, 8'h01);
        rd(2'd1, 1'b0, v); check("R1 status ready", v, 8'h01);
        rd(2'd0, 1'b0, v); check("R3 hold data", v, 8'h3C);
        check("R3 pin cleared", {7'd0, rx_ready_o}, 8'h00);

        chr(8'h41, 1'b1, 1'b0);
        rd(2'd1, 1'b0, v); check("R2 parity", v, 8'h03);
        chr(8'h42, 1'b0, 1'b1);
        rd(2'd1, 1'b0, v); check("R4 overrun+R2 framing", v, 8'h0F);
        rd(2'd0, 1'b0, v); check("R4 overwrite", v, 8'h42);
        rd(2'd1, 1'b0, v); check("R2 sticky", v, 8'h0E);

        wr(2'd3, 8'h00);
        rd(2'd1, 1'b0, v); check("R9 disable clears", v, 8'h00);
        check("R9 pin low", {7'd0, rx_ready_o}, 8'h00);

        // read and char in same cycle
        wr(2'd3, 8'h04);
        chr(8'h10, 1'b0, 1'b0);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = 2'd0; cpu_peek = 1'b0;
        char_done = 1'b1; char_data = 8'h20;
        #1 check("R3 old byte on collide", cpu_rdata, 8'h10);
        idle();
        rd(2'd1, 1'b0, v); check("R3 ready kept, R4 no overrun", v, 8'h01);
        rd(2'd0, 1'b0, v); check("R3 new byte", v, 8'h20);

        // disable and char in same cycle
        chr(8'h50, 1'b0, 1'b1);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = 2'd3; cpu_wdata = 8'h00;
        char_done = 1'b1; char_data = 8'h77; char_perr = 1'b1;
        idle();
        rd(2'd1, 1'b0, v); check("R9 char over clear", v, 8'h03);
        check("R9 cmd", cmd_o, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule